// File: doc/BRIEF.md
# Single-Bus Processor Datapath

This block is the register and ALU half of a small processor core in which every internal transfer travels over one shared 32-bit bus. It holds a program counter, a memory address register, a memory data register, an instruction register, eight general registers, an ALU operand latch Y and an ALU result latch Z. A sequencer outside the block supplies one control word per cycle. That word names the source gated onto the bus, the registers that capture the bus at the next clock edge, the ALU operation and its first-operand selection, and any memory request to start.

The ALU reads its second operand from the bus. Its first operand is Y or the constant 4. Its result can only be captured into Z, and Z must be gated back onto the bus in a later cycle before it reaches any other register. Fetch overlaps the program counter increment. In the first cycle the PC is copied to the address register, a read is issued and PC+4 is computed into Z. While the block waits for memory, Z is written back to the PC.

Memory traffic uses a request/complete handshake. A request raises the read or write strobe, and the strobe stays up, with address and write data held, until memory answers with a one-cycle completion pulse. Memory can stall for any number of cycles. The sequencer keeps its memory-side load enable raised while it waits, and the data register captures memory data only in the completion cycle.

Top module: `sb_datapath`

## Requirements
- R1: After reset the PC, MAR, MDR, IR, Y, Z, all eight general registers and the N flag are zero, and both memory strobes are low.
- R2: With exactly one source enable high, `bus_value` equals that source. With none high it is zero. The sources are PC, Z, MDR, the IR address field and the eight registers. Every register whose load enable is high captures `bus_value` at the clock edge, including PC (`ld_pc`) and MAR (`ld_mar`).
- R3: With two or more source enables high, `bus_value` is zero and `bus_conflict` is 1. Any register loaded in that cycle receives zero. With at most one source enable high, `bus_conflict` is 0.
- R4: The ALU computes A op B, where B is the bus and A is the constant 4 when `alu_sel_four`=1 and Y otherwise. The `alu_op` encoding is 0 = add, 1 = subtract (A-B), 2 = AND, 3 = OR. The result is captured into Z only when `ld_z`=1, and Z holds in every other cycle.
- R5: The N flag takes bit 31 of the ALU result whenever Z is loaded, and it holds otherwise.
- R6: The MDR captures `mem_rdata` when `ld_mdr_mem`=1 and `mem_mfc`=1. In that case memory data wins over the bus even if `ld_mdr_bus`=1. Otherwise the MDR captures the bus when `ld_mdr_bus`=1. `mem_wdata` always shows the MDR.
- R7: `mem_addr` always shows the MAR. A read (`mem_read_req`) or write (`mem_write_req`) request raises `mem_rd` or `mem_wr` from the next cycle onward. The strobe stays high until the clock edge of the cycle in which `mem_mfc`=1.
- R8: The IR address source drives IR bits 24..0 onto bus bits 24..0, with bits 31..25 forced to zero.
- R9: Each of the eight general registers has its own load enable and its own source enable. Several registers may load the same bus value in one cycle.
- R10: An overlapped fetch works in three steps. PC goes to MAR with a read and Z=4+PC. Then Z goes to PC while the block waits for completion. Then MDR goes to IR. At the end, PC has advanced by 4 and IR holds the word at the old PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_pc | input | 1 | Gate PC onto the bus |
| drv_z | input | 1 | Gate Z onto the bus |
| drv_mdr | input | 1 | Gate MDR onto the bus |
| drv_iraddr | input | 1 | Gate the zero-extended IR address field onto the bus |
| drv_reg | input | 8 | Per-register bus source enables, bit i = register i |
| ld_pc | input | 1 | Load PC from the bus |
| ld_mar | input | 1 | Load MAR from the bus |
| ld_mdr_bus | input | 1 | Load MDR from the bus |
| ld_mdr_mem | input | 1 | Load MDR from memory data in the completion cycle |
| ld_ir | input | 1 | Load IR from the bus |
| ld_y | input | 1 | Load Y from the bus |
| ld_z | input | 1 | Load Z and N from the ALU |
| ld_reg | input | 8 | Per-register load enables, bit i = register i |
| alu_sel_four | input | 1 | ALU A operand: 1 = constant 4, 0 = Y |
| alu_op | input | 2 | ALU operation: 0 add, 1 sub, 2 and, 3 or |
| mem_read_req | input | 1 | Start a memory read at MAR |
| mem_write_req | input | 1 | Start a memory write of MDR at MAR |
| mem_addr | output | 32 | Memory address (MAR) |
| mem_rd | output | 1 | Read strobe, held until completion |
| mem_wr | output | 1 | Write strobe, held until completion |
| mem_wdata | output | 32 | Write data (MDR) |
| mem_rdata | input | 32 | Read data from memory |
| mem_mfc | input | 1 | Memory function complete, one-cycle pulse |
| ir_word | output | 32 | Instruction register, for the decoder |
| n_flag | output | 1 | Registered negative flag |
| bus_value | output | 32 | Current internal bus value |
| bus_conflict | output | 1 | More than one bus source enabled this cycle |

## Verification
The bench runs control sequences that a real sequencer would issue, compares the outputs against a cycle model on every clock, and adds directed checks at each step.

- **Fetch, direct-address load and waits.** Two fetches and two direct-address loads run with memory delays of one to five cycles. These separate a correct strobe hold and completion-cycle capture from capture that happens too early or is dropped. The second instruction word has its upper bits set, which exposes a missing zero-fill of the address field.
- **ALU operations.** Add, subtract, AND, OR and the constant-4 increment use operands chosen so that both N values occur. These distinguish operand order, operation encoding and the A-operand mux.
- **Load-enable and bus corner cases.** A cycle without `ld_z` shows whether Z and N hold. A multi-register load tests the per-register enables. A two-source cycle and a no-source cycle tie down the defined zero bus.
- **Write and read-back.** A write followed by a read, with bus loads into MDR asserted during the wait, confirms that memory data has priority in the completion cycle.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_AND = 2'd2,
    ALU_OR  = 2'd3
  } alu_op_e;

  localparam int SB_DW   = 32;
  localparam int SB_NREG = 8;
  localparam int SB_AFW  = 25;
  localparam int SB_INC  = 4;
  // fixed source slots ahead of the register file on the bus
  localparam int SB_FIXED_SRC = 4;
endpackage

// File: rtl/sb_bus.sv
module sb_bus #(
  parameter int DW   = 32,
  parameter int NSRC = 12
) (
  input  logic [NSRC-1:0]         en,
  input  logic [NSRC-1:0][DW-1:0] src,
  output logic [DW-1:0]           bus,
  output logic                    conflict
);
  localparam int CW = $clog2(NSRC + 1);

  logic [NSRC-1:0][DW-1:0] gated;
  logic [DW-1:0]           merged;
  logic [CW-1:0]           active;

  for (genvar i = 0; i < NSRC; i++) begin : g_gate
    assign gated[i] = src[i] & {DW{en[i]}};
  end

  always_comb begin
    merged = '0;
    active = '0;
    for (int i = 0; i < NSRC; i++) begin
      merged = merged | gated[i];
      active = active + CW'(en[i]);
    end
  end

  assign conflict = (active > CW'(1));
  assign bus      = conflict ? '0 : merged;

  always_comb begin
    if (conflict) begin
      AST_CONFLICT_ZERO: assert (bus == '0); // R3
    end
  end
endmodule

// File: rtl/sb_regfile.sv
module sb_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NREG-1:0]         load,
  input  logic [DW-1:0]           bus,
  output logic [NREG-1:0][DW-1:0] q
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q[i] <= '0;
      else if (load[i]) q[i] <= bus;
    end

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load[i] |=> $stable(q[i])); // R9
  end
endmodule

// File: rtl/sb_alu.sv
module sb_alu
  import sb_pkg::*;
#(
  parameter int DW  = 32,
  parameter int INC = 4
) (
  input  logic          sel_four,
  input  logic [1:0]    op,
  input  logic [DW-1:0] y,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] result,
  output logic          neg
);
  logic [DW-1:0] a;
  alu_op_e       op_e;

  assign a    = sel_four ? DW'(INC) : y;
  assign op_e = alu_op_e'(op);

  always_comb begin
    unique case (op_e)
      ALU_ADD: result = a + b;
      ALU_SUB: result = a - b;
      ALU_AND: result = a & b;
      ALU_OR:  result = a | b;
      default: result = '0;
    endcase
  end

  assign neg = result[DW-1];
endmodule

// File: rtl/sb_datapath.sv
module sb_datapath
  import sb_pkg::*;
#(
  parameter int DW   = SB_DW,
  parameter int NREG = SB_NREG,
  parameter int AFW  = SB_AFW,
  parameter int INC  = SB_INC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            drv_pc,
  input  logic            drv_z,
  input  logic            drv_mdr,
  input  logic            drv_iraddr,
  input  logic [NREG-1:0] drv_reg,
  input  logic            ld_pc,
  input  logic            ld_mar,
  input  logic            ld_mdr_bus,
  input  logic            ld_mdr_mem,
  input  logic            ld_ir,
  input  logic            ld_y,
  input  logic            ld_z,
  input  logic [NREG-1:0] ld_reg,
  input  logic            alu_sel_four,
  input  logic [1:0]      alu_op,
  input  logic            mem_read_req,
  input  logic            mem_write_req,
  output logic [DW-1:0]   mem_addr,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_mfc,
  output logic [DW-1:0]   ir_word,
  output logic            n_flag,
  output logic [DW-1:0]   bus_value,
  output logic            bus_conflict
);
  localparam int NSRC = SB_FIXED_SRC + NREG;

  logic [DW-1:0] pc_q, mar_q, mdr_q, ir_q, y_q, z_q;
  logic          n_q, rd_q, wr_q;
  logic [DW-1:0] alu_res;
  logic          alu_neg;

  logic [NSRC-1:0]           src_en;
  logic [NSRC-1:0][DW-1:0]   src_val;
  logic [NREG-1:0][DW-1:0]   rf_q;

  assign src_en  = {drv_reg, drv_iraddr, drv_mdr, drv_z, drv_pc};
  assign src_val[0] = pc_q;
  assign src_val[1] = z_q;
  assign src_val[2] = mdr_q;
  assign src_val[3] = {{(DW-AFW){1'b0}}, ir_q[AFW-1:0]};
  for (genvar i = 0; i < NREG; i++) begin : g_src
    assign src_val[SB_FIXED_SRC+i] = rf_q[i];
  end

  sb_bus #(.DW(DW), .NSRC(NSRC)) bus_i (
    .en      (src_en),
    .src     (src_val),
    .bus     (bus_value),
    .conflict(bus_conflict)
  );

  sb_regfile #(.DW(DW), .NREG(NREG)) rf_i (
    .clk  (clk),
    .rst_n(rst_n),
    .load (ld_reg),
    .bus  (bus_value),
    .q    (rf_q)
  );

  sb_alu #(.DW(DW), .INC(INC)) alu_i (
    .sel_four(alu_sel_four),
    .op      (alu_op),
    .y       (y_q),
    .b       (bus_value),
    .result  (alu_res),
    .neg     (alu_neg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
      y_q   <= '0;
      z_q   <= '0;
      n_q   <= 1'b0;
    end else begin
      if (ld_pc)  pc_q  <= bus_value;
      if (ld_mar) mar_q <= bus_value;
      if (ld_ir)  ir_q  <= bus_value;
      if (ld_y)   y_q   <= bus_value;
      if (ld_z) begin
        z_q <= alu_res;
        n_q <= alu_neg;
      end
      if (ld_mdr_mem && mem_mfc) mdr_q <= mem_rdata;
      else if (ld_mdr_bus)       mdr_q <= bus_value;
    end
  end

  // memory strobes: a request wins over a completion in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      if (mem_read_req)  rd_q <= 1'b1;
      else if (mem_mfc)  rd_q <= 1'b0;
      if (mem_write_req) wr_q <= 1'b1;
      else if (mem_mfc)  wr_q <= 1'b0;
    end
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;
  assign mem_rd    = rd_q;
  assign mem_wr    = wr_q;
  assign ir_word   = ir_q;
  assign n_flag    = n_q;

  AST_PC_FROM_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_pc |=> pc_q == $past(bus_value)); // R2
  AST_MAR_FROM_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_mar |=> mem_addr == $past(bus_value)); // R7
  AST_Z_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_z |=> $stable(z_q)); // R4
  AST_N_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_z |=> $stable(n_flag)); // R5
  AST_MDR_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_mdr_mem && mem_mfc) |=> mem_wdata == $past(mem_rdata)); // R6
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_mfc) |=> mem_rd); // R7
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_mfc) |=> mem_wr); // R7
  AST_IRADDR_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_iraddr && !bus_conflict) |-> bus_value[DW-1:AFW] == '0); // R8
endmodule

// File: tb/sb_datapath_tb_top.sv
module sb_datapath_tb_top;
  localparam int DW = 32;
  localparam int NR = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic drv_pc, drv_z, drv_mdr, drv_iraddr;
  logic [NR-1:0] drv_reg, ld_reg;
  logic ld_pc, ld_mar, ld_mdr_bus, ld_mdr_mem, ld_ir, ld_y, ld_z;
  logic alu_sel_four;
  logic [1:0] alu_op;
  logic mem_read_req, mem_write_req;
  logic [DW-1:0] mem_addr, mem_wdata, mem_rdata, ir_word, bus_value;
  logic mem_rd, mem_wr, mem_mfc, n_flag, bus_conflict;

  sb_datapath dut_i (
    .clk(clk), .rst_n(rst_n),
    .drv_pc(drv_pc), .drv_z(drv_z), .drv_mdr(drv_mdr), .drv_iraddr(drv_iraddr),
    .drv_reg(drv_reg),
    .ld_pc(ld_pc), .ld_mar(ld_mar), .ld_mdr_bus(ld_mdr_bus), .ld_mdr_mem(ld_mdr_mem),
    .ld_ir(ld_ir), .ld_y(ld_y), .ld_z(ld_z), .ld_reg(ld_reg),
    .alu_sel_four(alu_sel_four), .alu_op(alu_op),
    .mem_read_req(mem_read_req), .mem_write_req(mem_write_req),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_mfc(mem_mfc),
    .ir_word(ir_word), .n_flag(n_flag), .bus_value(bus_value), .bus_conflict(bus_conflict)
  );

  int total = 0;
  int bad = 0;

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [DW-1:0] m_pc, m_mar, m_mdr, m_ir, m_y, m_z;
  logic [DW-1:0] m_reg [NR];
  logic m_n, m_rd, m_wr;

  function automatic int n_drivers();
    int c = 0;
    c += int'(drv_pc) + int'(drv_z) + int'(drv_mdr) + int'(drv_iraddr);
    for (int i = 0; i < NR; i++) c += int'(drv_reg[i]);
    return c;
  endfunction

  function automatic logic [DW-1:0] model_bus();
    if (n_drivers() != 1) return '0;
    if (drv_pc) return m_pc;
    if (drv_z) return m_z;
    if (drv_mdr) return m_mdr;
    if (drv_iraddr) return m_ir & 32'h01FF_FFFF;
    for (int i = 0; i < NR; i++) if (drv_reg[i]) return m_reg[i];
    return '0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pc = 0; m_mar = 0; m_mdr = 0; m_ir = 0; m_y = 0; m_z = 0;
      m_n = 0; m_rd = 0; m_wr = 0;
      for (int i = 0; i < NR; i++) m_reg[i] = 0;
    end else begin
      logic [DW-1:0] b, a, r;
      b = model_bus();
      a = alu_sel_four ? 32'd4 : m_y;
      case (alu_op)
        2'd0: r = a + b;
        2'd1: r = a - b;
        2'd2: r = a & b;
        default: r = a | b;
      endcase
      if (ld_pc) m_pc = b;
      if (ld_mar) m_mar = b;
      if (ld_ir) m_ir = b;
      if (ld_y) m_y = b;
      if (ld_z) begin m_z = r; m_n = r[31]; end
      if (ld_mdr_mem && mem_mfc) m_mdr = mem_rdata;
      else if (ld_mdr_bus) m_mdr = b;
      for (int i = 0; i < NR; i++) if (ld_reg[i]) m_reg[i] = b;
      if (mem_read_req) m_rd = 1; else if (mem_mfc) m_rd = 0;
      if (mem_write_req) m_wr = 1; else if (mem_mfc) m_wr = 0;
    end
  end

  // ---------------- memory model ----------------
  logic [DW-1:0] mem [64];
  int cnt = 0;
  int dly_idx = 0;
  int dly_tab [4] = '{1, 3, 2, 5};

  task automatic mem_step();
    mem_mfc = 1'b0;
    if (mem_rd || mem_wr) begin
      if (cnt == 0) begin
        cnt = dly_tab[dly_idx];
        dly_idx = (dly_idx + 1) % 4;
      end
      cnt--;
      if (cnt == 0) begin
        mem_mfc = 1'b1;
        if (mem_wr) mem[mem_addr[7:2]] = mem_wdata;
        else mem_rdata = mem[mem_addr[7:2]];
      end
    end
  endtask

  task automatic clear_ctl();
    drv_pc = 0; drv_z = 0; drv_mdr = 0; drv_iraddr = 0; drv_reg = '0;
    ld_pc = 0; ld_mar = 0; ld_mdr_bus = 0; ld_mdr_mem = 0; ld_ir = 0;
    ld_y = 0; ld_z = 0; ld_reg = '0;
    alu_sel_four = 0; alu_op = 2'd0; mem_read_req = 0; mem_write_req = 0;
  endtask

  // inputs are set just after a falling edge; tick completes one cycle
  task automatic tick();
    #1;
    check("R2 bus", bus_value, model_bus());
    check("R3 conflict", {31'd0, bus_conflict}, {31'd0, n_drivers() > 1});
    @(posedge clk);
    @(negedge clk);
    check("R7 addr", mem_addr, m_mar);
    check("R7 rd", {31'd0, mem_rd}, {31'd0, m_rd});
    check("R7 wr", {31'd0, mem_wr}, {31'd0, m_wr});
    check("R6 wdata", mem_wdata, m_mdr);
    check("R5 n", {31'd0, n_flag}, {31'd0, m_n});
    check("R10 ir", ir_word, m_ir);
    mem_step();
    clear_ctl();
  endtask

  task automatic peek_src(input int which, input logic [DW-1:0] exp, input string tag);
    case (which)
      100: drv_pc = 1;
      101: drv_z = 1;
      102: drv_mdr = 1;
      103: drv_iraddr = 1;
      default: drv_reg[which] = 1;
    endcase
    #1;
    check(tag, bus_value, exp);
    tick();
  endtask

  task automatic wait_mem(input bit fetch_mode, input bit is_write, input bit mdr_bus_too);
    bit done;
    int guard = 0;
    do begin
      if (!is_write) ld_mdr_mem = 1;
      if (fetch_mode) begin drv_z = 1; ld_pc = 1; end
      if (mdr_bus_too) begin drv_reg[1] = 1; ld_mdr_bus = 1; end
      done = mem_mfc;
      tick();
      guard++;
    end while (!done && guard < 50);
    if (!done) check("R7 completion", 0, 1);
  endtask

  task automatic fetch();
    drv_pc = 1; ld_mar = 1; mem_read_req = 1; alu_sel_four = 1; alu_op = 2'd0; ld_z = 1;
    tick();
    wait_mem(1, 0, 0);
    drv_mdr = 1; ld_ir = 1;
    tick();
  endtask

  task automatic load_direct(input int k);
    drv_iraddr = 1; ld_mar = 1; mem_read_req = 1;
    tick();
    wait_mem(0, 0, 0);
    drv_mdr = 1; ld_reg[k] = 1;
    tick();
  endtask

  task automatic alu_rr(input int ra, input int rb, input logic [1:0] op, input int rd);
    drv_reg[ra] = 1; ld_y = 1;
    tick();
    drv_reg[rb] = 1; alu_op = op; ld_z = 1;
    tick();
    drv_z = 1; ld_reg[rd] = 1;
    tick();
  endtask

  localparam logic [DW-1:0] VA = 32'h1234_5678;
  localparam logic [DW-1:0] VB = 32'h8000_0001;

  initial begin
    #50000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'hA5A5_0000 + i;
    mem[0]  = 32'h0000_0040;
    mem[1]  = 32'hFE00_0044;
    mem[16] = VA;
    mem[17] = VB;
    mem_mfc = 0;
    mem_rdata = '0;
    clear_ctl();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 rd", {31'd0, mem_rd}, 32'd0);
    check("R1 wr", {31'd0, mem_wr}, 32'd0);
    check("R1 n", {31'd0, n_flag}, 32'd0);
    check("R1 addr", mem_addr, 32'd0);
    peek_src(100, 0, "R1 pc");
    peek_src(101, 0, "R1 z");
    peek_src(102, 0, "R1 mdr");
    peek_src(103, 0, "R1 iraddr");
    for (int i = 0; i < NR; i++) peek_src(i, 0, "R1 reg");
    #1 check("R2 idle bus", bus_value, 32'd0);
    tick();

    // R10 first fetch
    fetch();
    check("R10 ir word", ir_word, 32'h0000_0040);
    peek_src(100, 32'd4, "R10 pc+4");
    load_direct(1);
    peek_src(1, VA, "R9 r1");
    fetch();
    check("R10 ir word2", ir_word, 32'hFE00_0044);
    peek_src(103, 32'h0000_0044, "R8 zero fill");
    peek_src(100, 32'd8, "R10 pc+8");
    load_direct(2);
    peek_src(2, VB, "R9 r2");

    // R4 R5 ALU
    alu_rr(1, 2, 2'd0, 3);
    peek_src(3, VA + VB, "R4 add");
    check("R5 n set", {31'd0, n_flag}, 32'd1);
    alu_rr(2, 1, 2'd1, 4);
    peek_src(4, VB - VA, "R4 sub");
    check("R5 n clr", {31'd0, n_flag}, 32'd0);
    alu_rr(1, 2, 2'd2, 5);
    peek_src(5, VA & VB, "R4 and");
    alu_rr(1, 2, 2'd3, 6);
    peek_src(6, VA | VB, "R4 or");
    drv_reg[3] = 1; alu_sel_four = 1; ld_z = 1;
    tick();
    peek_src(101, (VA + VB) + 32'd4, "R4 four");
    check("R5 n four", {31'd0, n_flag}, 32'd1);
    drv_reg[4] = 1; alu_op = 2'd1;
    tick();
    peek_src(101, (VA + VB) + 32'd4, "R4 z hold");
    check("R5 n hold", {31'd0, n_flag}, 32'd1);

    // R9 multi load
    drv_reg[4] = 1; ld_reg[5] = 1; ld_reg[6] = 1;
    tick();
    peek_src(5, VB - VA, "R9 multi r5");
    peek_src(6, VB - VA, "R9 multi r6");

    // R7 write then read back, R6 memory priority
    drv_reg[4] = 1; ld_mdr_bus = 1;
    tick();
    drv_iraddr = 1; ld_mar = 1; mem_write_req = 1;
    tick();
    check("R7 wr up", {31'd0, mem_wr}, 32'd1);
    check("R7 wdata", mem_wdata, VB - VA);
    wait_mem(0, 1, 0);
    check("R7 wr down", {31'd0, mem_wr}, 32'd0);
    drv_reg[0] = 1; ld_mdr_bus = 1;
    tick();
    drv_iraddr = 1; ld_mar = 1; mem_read_req = 1;
    tick();
    wait_mem(0, 0, 1);
    peek_src(102, VB - VA, "R6 mem priority");
    drv_mdr = 1; ld_reg[7] = 1;
    tick();
    peek_src(7, VB - VA, "R6 readback");

    // R3 conflict
    drv_reg[1] = 1; ld_reg[0] = 1;
    tick();
    peek_src(0, VA, "R2 r0");
    drv_reg[1] = 1; drv_reg[2] = 1; ld_reg[0] = 1;
    #1;
    check("R3 bus zero", bus_value, 32'd0);
    check("R3 flag", {31'd0, bus_conflict}, 32'd1);
    tick();
    peek_src(0, 32'd0, "R3 r0 zero");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule